// File: doc/BRIEF.md
# Four-Channel PCM Time-Slot Interface

This block connects four codec channels to two serial PCM highways, called A and B. A single frame sync marks the start of every frame for all four channels. Behind each frame-sync rising edge the block counts bit-clock periods. A programmable delay of 0, 1 or 7 bit clocks turns that count into a frame position. Every group of eight positions forms one time slot.

Each channel has a transmit slot and a receive slot, set independently, and a routing mask. The mask sends its transmit byte to highway A, highway B, both, or neither. A receive-port select picks the highway it listens to. On transmit, a highway drives its output enable only while an active channel owns the current slot. On receive, the block shifts in the channel's slot and hands the finished word over with a one-cycle valid pulse. A channel in power-down neither drives nor captures. A channel in 16-bit linear mode uses two consecutive slots in each direction.

The block runs on a fast system clock. Bit clock and frame sync are generated on-chip, in step with that clock, and the block detects their edges.

Top module: `pcm_tsi`

## Requirements
- R1: After reset both output enables are low, both serial outputs are 0, every rx_valid bit is low and every rx_word is zero.
- R2: Count 0 is the bit-clock period whose rising edge is the first to see fsync high. Frame position equals count minus the delay. The delay is 0 for cfg_dly 0 or 3, 1 for cfg_dly 1 and 7 for cfg_dly 2. Counts below the delay belong to no slot.
- R3: Slot n covers frame positions 8n to 8n+7. In 8-bit mode a channel sends tx_word[7:0] MSB first, so bit 7 goes out at position 8n.
- R4: Outside the slots owned by an active channel routed to it, a highway keeps its output enable low and its data output at 0.
- R5: With cfg_tx_fall = 0 a transmit bit changes only after a bit-clock rising edge. With cfg_tx_fall = 1 it changes only after a falling edge.
- R6: Receive bits are sampled on the bit-clock falling edge. After the last bit of the channel's slot, rx_word is updated and rx_valid pulses for one clock. In 8-bit mode the upper byte of rx_word is zero and the first bit received lands in bit 7.
- R7: ch_route bit 2c enables channel c on highway A and bit 2c+1 enables it on highway B. Both bits may be set, and with neither set the channel does not transmit.
- R8: ch_rx_b bit c = 0 makes channel c receive from dr_a, and 1 makes it receive from dr_b.
- R9: A channel's transmit slot and receive slot are independent and may differ.
- R10: A channel with ch_pdn set never drives its transmit slot. It never pulses rx_valid, and its rx_word keeps its previous value.
- R11: With ch_lin set, a channel uses slot s and slot s+1 in each direction. Transmit sends tx_word[15:8] MSB first in slot s, then tx_word[7:0]. On receive, the first bit of slot s lands in rx_word[15].
- R12: When several channels that are not powered down and are routed to the same highway claim the current slot, the lowest-numbered one drives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | PCM bit clock, synchronous to clk |
| fsync | input | 1 | Frame sync, shared by all channels |
| cfg_dly | input | 2 | Frame reference delay code |
| cfg_tx_fall | input | 1 | Transmit launch edge: 0 rising, 1 falling |
| ch_tx_slot | input | NCH*SLOT_W | Transmit slot number per channel |
| ch_rx_slot | input | NCH*SLOT_W | Receive slot number per channel |
| ch_route | input | 2*NCH | Transmit highway enables, two bits per channel |
| ch_rx_b | input | NCH | Receive highway select per channel |
| ch_pdn | input | NCH | Power-down per channel |
| ch_lin | input | NCH | 16-bit linear mode per channel |
| tx_word | input | NCH*16 | Transmit word per channel |
| dx_a | output | 1 | Highway A serial data |
| dx_a_oe | output | 1 | Highway A output enable (low = high impedance) |
| dx_b | output | 1 | Highway B serial data |
| dx_b_oe | output | 1 | Highway B output enable |
| dr_a | input | 1 | Highway A serial receive input |
| dr_b | input | 1 | Highway B serial receive input |
| rx_word | output | NCH*16 | Last received word per channel |
| rx_valid | output | NCH | One-cycle pulse when rx_word of that channel updates |

## Verification
A transmit bit appears at the first clk edge after the bit-clock edge that launches it. The bench samples each bit period twice. The first sample is three clocks after the rising edge, when a rising-edge launch has settled but a falling-edge launch must still show the previous bit. The second is six clocks after, behind the falling edge, when either mode shows the current bit. A receive word and its rx_valid pulse arrive at the first clk edge after the falling edge of the slot's last bit. The bench queues each expected word at the start of that bit period and compares it at the clk falling edge where the pulse is seen.

// File: rtl/pcm_tsi_pkg.sv
package pcm_tsi_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;
    localparam int NPORT  = 2;

    typedef enum logic [1:0] {
        FR_DLY_0   = 2'd0,
        FR_DLY_1   = 2'd1,
        FR_DLY_7   = 2'd2,
        FR_DLY_RSV = 2'd3
    } fr_dly_e;

    // Bit-clock periods between frame sync and position zero
    function automatic logic [3:0] frame_delay(input logic [1:0] code);
        logic [3:0] n;
        case (code)
            FR_DLY_1: n = 4'd1;
            FR_DLY_7: n = 4'd7;
            default:  n = 4'd0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/pcm_tsi_timing.sv
module pcm_tsi_timing
    import pcm_tsi_pkg::*;
#(
    parameter  int SLOT_W = 7,
    localparam int POS_W  = SLOT_W + 3,
    localparam int RAW_W  = POS_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk,
    input  logic             fsync,
    input  logic [1:0]       dly_sel,
    output logic             rise_stb,
    output logic             fall_stb,
    output logic             pos_ok,
    output logic [POS_W-1:0] pos
);

    localparam logic [RAW_W-1:0] RAW_MAX = {RAW_W{1'b1}};
    localparam logic [RAW_W-1:0] RAW_ONE = RAW_W'(1);

    typedef struct packed {
        logic             bclk;
        logic             fs;
        logic [RAW_W-1:0] raw;
    } tim_s;

    tim_s             st_d, st_q;
    logic [RAW_W-1:0] cur_raw;
    logic [RAW_W-1:0] dly_w;
    logic [RAW_W-1:0] diff;

    always_comb begin
        st_d      = st_q;
        st_d.bclk = bclk;
        rise_stb  = bclk & ~st_q.bclk;
        fall_stb  = ~bclk & st_q.bclk;
        if (rise_stb) begin
            st_d.fs = fsync;
            if (fsync && !st_q.fs) begin
                st_d.raw = '0;
            end else if (st_q.raw != RAW_MAX) begin
                st_d.raw = st_q.raw + RAW_ONE;
            end
        end
        cur_raw = rise_stb ? st_d.raw : st_q.raw;
        dly_w   = RAW_W'(frame_delay(dly_sel));
        diff    = cur_raw - dly_w;
        pos_ok  = (cur_raw >= dly_w) && !diff[RAW_W-1];
        pos     = diff[POS_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{bclk: 1'b0, fs: 1'b0, raw: RAW_MAX};
        end else begin
            st_q <= st_d;
        end
    end

    AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_stb && fsync && !st_q.fs) |=> (st_q.raw == '0)); // R2

    AST_COUNT_ON_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !rise_stb |=> $stable(st_q.raw)); // R2

endmodule

// File: rtl/pcm_tsi_tx_port.sv
module pcm_tsi_tx_port
    import pcm_tsi_pkg::*;
#(
    parameter  int NCH    = 4,
    parameter  int SLOT_W = 7,
    localparam int POS_W  = SLOT_W + 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    launch,
    input  logic                    pos_ok,
    input  logic [POS_W-1:0]        pos,
    input  logic [NCH-1:0]          route,
    input  logic [NCH-1:0]          pdn,
    input  logic [NCH-1:0]          lin,
    input  logic [NCH*SLOT_W-1:0]   slot_cfg,
    input  logic [NCH*WORD_W-1:0]   word_cfg,
    output logic                    dx,
    output logic                    dx_oe
);

    localparam logic [SLOT_W:0] SLOT_ONE = (SLOT_W + 1)'(1);

    typedef struct packed {
        logic dat;
        logic oe;
    } txo_s;

    txo_s              st_d, st_q;
    logic [NCH-1:0]    hit;
    logic [NCH-1:0]    bitv;
    logic [SLOT_W-1:0] cur_slot;
    logic [2:0]        cur_bit;
    logic              any_hit;
    logic              sel_bit;

    assign cur_slot = pos[POS_W-1:3];
    assign cur_bit  = pos[2:0];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [SLOT_W-1:0] ts;
        logic [WORD_W-1:0] wd;
        logic              in_first;
        logic              in_second;
        logic [3:0]        idx;

        assign ts        = slot_cfg[c*SLOT_W +: SLOT_W];
        assign wd        = word_cfg[c*WORD_W +: WORD_W];
        assign in_first  = (cur_slot == ts);
        assign in_second = lin[c] && ({1'b0, cur_slot} == ({1'b0, ts} + SLOT_ONE));
        assign idx       = (lin[c] && in_first) ? (4'd15 - {1'b0, cur_bit})
                                                : (4'd7 - {1'b0, cur_bit});
        assign hit[c]    = pos_ok && route[c] && !pdn[c] && (in_first || in_second);
        assign bitv[c]   = wd[idx];
    end

    always_comb begin
        any_hit = 1'b0;
        sel_bit = 1'b0;
        for (int c = NCH - 1; c >= 0; c--) begin
            if (hit[c]) begin
                any_hit = 1'b1;
                sel_bit = bitv[c];
            end
        end
        st_d = st_q;
        if (launch) begin
            st_d.oe  = any_hit;
            st_d.dat = any_hit & sel_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{dat: 1'b0, oe: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign dx    = st_q.dat;
    assign dx_oe = st_q.oe;

    AST_TX_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !launch |=> $stable({dx, dx_oe})); // R5

    AST_TX_PDN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && (&pdn)) |=> !dx_oe); // R10

    AST_TX_UNROUTED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && (route == '0)) |=> !dx_oe); // R7

endmodule

// File: rtl/pcm_tsi_rx_chan.sv
module pcm_tsi_rx_chan
    import pcm_tsi_pkg::*;
#(
    parameter  int SLOT_W = 7,
    localparam int POS_W  = SLOT_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic              pos_ok,
    input  logic [POS_W-1:0]  pos,
    input  logic              dr_a,
    input  logic              dr_b,
    input  logic              sel_b,
    input  logic              pdn,
    input  logic              lin,
    input  logic [SLOT_W-1:0] slot,
    output logic [WORD_W-1:0] word,
    output logic              valid
);

    localparam logic [SLOT_W:0] SLOT_ONE = (SLOT_W + 1)'(1);

    typedef struct packed {
        logic [WORD_W-2:0] sh;
        logic [WORD_W-1:0] word;
        logic              valid;
    } rxs_s;

    rxs_s              st_d, st_q;
    logic [SLOT_W-1:0] cur_slot;
    logic              in_first;
    logic              in_second;
    logic              take;
    logic              last;
    logic              bit_in;

    assign cur_slot  = pos[POS_W-1:3];
    assign in_first  = (cur_slot == slot);
    assign in_second = lin && ({1'b0, cur_slot} == ({1'b0, slot} + SLOT_ONE));
    assign take      = sample && pos_ok && !pdn && (in_first || in_second);
    assign last      = (pos[2:0] == 3'd7) && (lin ? in_second : in_first);
    assign bit_in    = sel_b ? dr_b : dr_a;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (take) begin
            st_d.sh = {st_q.sh[WORD_W-3:0], bit_in};
            if (last) begin
                st_d.valid = 1'b1;
                if (lin) begin
                    st_d.word = {st_q.sh, bit_in};
                end else begin
                    st_d.word = {{(WORD_W - BYTE_W){1'b0}}, st_q.sh[BYTE_W-2:0], bit_in};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word  = st_q.word;
    assign valid = st_q.valid;

    AST_RX_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid); // R6

    AST_RX_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(sample)); // R6

    AST_RX_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> $stable(word)); // R6

    AST_RX_PDN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        pdn |=> !valid); // R10

endmodule

// File: rtl/pcm_tsi.sv
module pcm_tsi
    import pcm_tsi_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int SLOT_W = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bclk,
    input  logic                  fsync,
    input  logic [1:0]            cfg_dly,
    input  logic                  cfg_tx_fall,
    input  logic [NCH*SLOT_W-1:0] ch_tx_slot,
    input  logic [NCH*SLOT_W-1:0] ch_rx_slot,
    input  logic [2*NCH-1:0]      ch_route,
    input  logic [NCH-1:0]        ch_rx_b,
    input  logic [NCH-1:0]        ch_pdn,
    input  logic [NCH-1:0]        ch_lin,
    input  logic [NCH*16-1:0]     tx_word,
    output logic                  dx_a,
    output logic                  dx_a_oe,
    output logic                  dx_b,
    output logic                  dx_b_oe,
    input  logic                  dr_a,
    input  logic                  dr_b,
    output logic [NCH*16-1:0]     rx_word,
    output logic [NCH-1:0]        rx_valid
);

    localparam int POS_W = SLOT_W + 3;

    logic             rise_stb;
    logic             fall_stb;
    logic             pos_ok;
    logic [POS_W-1:0] pos;
    logic             launch;
    logic [NPORT-1:0] dx_w;
    logic [NPORT-1:0] oe_w;

    pcm_tsi_timing #(.SLOT_W(SLOT_W)) u_timing (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk     (bclk),
        .fsync    (fsync),
        .dly_sel  (cfg_dly),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .pos_ok   (pos_ok),
        .pos      (pos)
    );

    assign launch = cfg_tx_fall ? fall_stb : rise_stb;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic [NCH-1:0] route_p;
        for (genvar c = 0; c < NCH; c++) begin : g_rt
            assign route_p[c] = ch_route[NPORT*c + p];
        end

        pcm_tsi_tx_port #(.NCH(NCH), .SLOT_W(SLOT_W)) u_tx (
            .clk      (clk),
            .rst_n    (rst_n),
            .launch   (launch),
            .pos_ok   (pos_ok),
            .pos      (pos),
            .route    (route_p),
            .pdn      (ch_pdn),
            .lin      (ch_lin),
            .slot_cfg (ch_tx_slot),
            .word_cfg (tx_word),
            .dx       (dx_w[p]),
            .dx_oe    (oe_w[p])
        );
    end

    assign dx_a    = dx_w[0];
    assign dx_a_oe = oe_w[0];
    assign dx_b    = dx_w[1];
    assign dx_b_oe = oe_w[1];

    for (genvar c = 0; c < NCH; c++) begin : g_rx
        pcm_tsi_rx_chan #(.SLOT_W(SLOT_W)) u_rx (
            .clk    (clk),
            .rst_n  (rst_n),
            .sample (fall_stb),
            .pos_ok (pos_ok),
            .pos    (pos),
            .dr_a   (dr_a),
            .dr_b   (dr_b),
            .sel_b  (ch_rx_b[c]),
            .pdn    (ch_pdn[c]),
            .lin    (ch_lin[c]),
            .slot   (ch_rx_slot[c*SLOT_W +: SLOT_W]),
            .word   (rx_word[c*16 +: 16]),
            .valid  (rx_valid[c])
        );
    end

endmodule

// File: tb/pcm_tsi_test.sv
module pcm_tsi_test;

    localparam int NCH = 4;
    localparam int SW  = 7;
    localparam int FL  = 256;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bclk = 1'b0;
    logic            fsync = 1'b0;
    logic [1:0]      cfg_dly = 2'd0;
    logic            cfg_tx_fall = 1'b0;
    logic [NCH*SW-1:0] ch_tx_slot = '0;
    logic [NCH*SW-1:0] ch_rx_slot = '0;
    logic [2*NCH-1:0]  ch_route = '0;
    logic [NCH-1:0]    ch_rx_b = '0;
    logic [NCH-1:0]    ch_pdn = '1;
    logic [NCH-1:0]    ch_lin = '0;
    logic [NCH*16-1:0] tx_word = '0;
    logic            dr_a = 1'b0;
    logic            dr_b = 1'b0;
    logic            dx_a, dx_a_oe, dx_b, dx_b_oe;
    logic [NCH*16-1:0] rx_word;
    logic [NCH-1:0]    rx_valid;

    int n_chk = 0;
    int n_fail = 0;
    int frm = 0;
    bit done = 0;
    string tx_tag = "R3 R4";
    logic [3:0]  txq[$];
    logic [17:0] rxq[$];
    logic [15:0] last_rx[NCH];

    always #4 clk = ~clk;

    pcm_tsi #(.NCH(NCH), .SLOT_W(SW)) uut (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync),
        .cfg_dly(cfg_dly), .cfg_tx_fall(cfg_tx_fall),
        .ch_tx_slot(ch_tx_slot), .ch_rx_slot(ch_rx_slot), .ch_route(ch_route),
        .ch_rx_b(ch_rx_b), .ch_pdn(ch_pdn), .ch_lin(ch_lin), .tx_word(tx_word),
        .dx_a(dx_a), .dx_a_oe(dx_a_oe), .dx_b(dx_b), .dx_b_oe(dx_b_oe),
        .dr_a(dr_a), .dr_b(dr_b), .rx_word(rx_word), .rx_valid(rx_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (frame %0d, t=%0t)", req, act, exp, frm, $time);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    function automatic int dly_bits();
        return (cfg_dly == 2'd1) ? 1 : (cfg_dly == 2'd2) ? 7 : 0;
    endfunction

    function automatic logic pat(input int port, input int f, input int p);
        int h;
        h = p * 29 + f * 17 + port * 101 + (p >> 3) * 5;
        return h[3] ^ h[0];
    endfunction

    // Expected {oe_a, dx_a, oe_b, dx_b} for bit period with count k
    function automatic logic [3:0] exp_tx(input int k);
        logic [3:0] r;
        int dl, p, slot, b, ts;
        logic [15:0] w;
        r  = 4'b0000;
        dl = dly_bits();
        if (k < dl) return r;
        p = k - dl;
        slot = p / 8;
        b = p % 8;
        for (int port = 0; port < 2; port++) begin
            bit found = 0;
            logic v = 1'b0;
            for (int c = 0; c < NCH; c++) begin
                ts = int'(ch_tx_slot[c*SW +: SW]);
                w  = tx_word[c*16 +: 16];
                if (!found && !ch_pdn[c] && ch_route[2*c + port]) begin
                    if (slot == ts) begin
                        found = 1;
                        v = ch_lin[c] ? w[15 - b] : w[7 - b];
                    end else if (ch_lin[c] && slot == ts + 1) begin
                        found = 1;
                        v = w[7 - b];
                    end
                end
            end
            if (port == 0) r[3:2] = {found, v};
            else           r[1:0] = {found, v};
        end
        return r;
    endfunction

    function automatic logic [15:0] exp_rx(input int c);
        logic [15:0] w;
        int base, port, nb;
        w = '0;
        port = int'(ch_rx_b[c]);
        base = int'(ch_rx_slot[c*SW +: SW]) * 8;
        nb = ch_lin[c] ? 16 : 8;
        for (int j = 0; j < nb; j++) w[nb - 1 - j] = pat(port, frm, base + j);
        return w;
    endfunction

    task automatic set_ch(input int c, input int ts, input int rs, input logic [1:0] rt,
                          input logic rb, input logic pd, input logic ln, input logic [15:0] w);
        ch_tx_slot[c*SW +: SW] = SW'(ts);
        ch_rx_slot[c*SW +: SW] = SW'(rs);
        ch_route[2*c +: 2]     = rt;
        ch_rx_b[c]             = rb;
        ch_pdn[c]              = pd;
        ch_lin[c]              = ln;
        tx_word[c*16 +: 16]    = w;
    endtask

    task automatic run_frame();
        int dl, lastp;
        dl = dly_bits();
        for (int k = 0; k < FL; k++) begin
            @(negedge clk);
            txq.push_back(exp_tx(k));
            for (int c = 0; c < NCH; c++) begin
                lastp = (int'(ch_rx_slot[c*SW +: SW]) + (ch_lin[c] ? 1 : 0)) * 8 + 7;
                if (!ch_pdn[c] && k >= dl && k - dl == lastp) begin
                    rxq.push_back({2'(c), exp_rx(c)});
                    last_rx[c] = exp_rx(c);
                end
            end
            dr_a  = (k >= dl) ? pat(0, frm, k - dl) : 1'b0;
            dr_b  = (k >= dl) ? pat(1, frm, k - dl) : 1'b0;
            fsync = (k == 0);
            bclk  = 1'b1;
            repeat (3) @(negedge clk);
            @(negedge clk);
            bclk = 1'b0;
            repeat (3) @(negedge clk);
        end
        frm++;
    endtask

    // Transmit monitor: checks R5 edge and R3/R4/R7/R11/R12 content
    initial begin
        logic [3:0] cur, prev, got;
        prev = 4'b0000;
        forever begin
            @(posedge bclk);
            if (txq.size() == 0) begin
                chk(0, "R4 transmit queue empty", 0, 0);
                cur = 4'b0000;
            end else begin
                cur = txq.pop_front();
            end
            repeat (3) @(negedge clk);
            got = {dx_a_oe, dx_a, dx_b_oe, dx_b};
            if (cfg_tx_fall) chk(got == prev, "R5 falling-edge launch holds previous bit", 32'(got), 32'(prev));
            else             chk(got == cur, {"R5 rising-edge launch ", tx_tag}, 32'(got), 32'(cur));
            repeat (3) @(negedge clk);
            got = {dx_a_oe, dx_a, dx_b_oe, dx_b};
            chk(got == cur, {"tx bit ", tx_tag}, 32'(got), 32'(cur));
            prev = cur;
        end
    end

    // Receive monitor: R6 R8 R9 R11
    initial begin
        logic [17:0] e;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                for (int c = 0; c < NCH; c++) begin
                    if (rx_valid[c]) begin
                        if (rxq.size() == 0) begin
                            chk(0, "R6 R10 unexpected rx_valid", 32'(c), 32'hffff);
                        end else begin
                            e = rxq.pop_front();
                            chk(e == {2'(c), rx_word[c*16 +: 16]}, "R6 R8 R9 R11 rx word",
                                32'({2'(c), rx_word[c*16 +: 16]}), 32'(e));
                        end
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(0, "watchdog expired", 0, 0);
            summary();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({dx_a_oe, dx_b_oe, dx_a, dx_b} == 4'b0, "R1 outputs idle", 32'({dx_a_oe, dx_b_oe, dx_a, dx_b}), 0);
        chk(rx_valid == '0, "R1 rx_valid low", 32'(rx_valid), 0);
        chk(rx_word == '0, "R1 rx_word zero", rx_word[31:0], 0);

        // Phase 1: no delay, rising edge, 8-bit, routing and priority
        tx_tag = "R3 R4 R7 R12";
        cfg_dly = 2'd0; cfg_tx_fall = 1'b0;
        set_ch(0, 0, 2, 2'b01, 1'b0, 1'b0, 1'b0, 16'h12A5);
        set_ch(1, 3, 2, 2'b10, 1'b1, 1'b0, 1'b0, 16'h00C3);
        set_ch(2, 5, 7, 2'b11, 1'b0, 1'b0, 1'b0, 16'hFF5E);
        set_ch(3, 0, 0, 2'b01, 1'b1, 1'b0, 1'b0, 16'h003C);
        run_frame(); run_frame();

        // Phase 2: delay 1, falling edge, linear, power-down
        tx_tag = "R2 R10 R11 R12";
        cfg_dly = 2'd1; cfg_tx_fall = 1'b1;
        set_ch(0, 10, 4, 2'b01, 1'b0, 1'b1, 1'b0, 16'hFFFF);
        set_ch(1, 10, 4, 2'b01, 1'b0, 1'b0, 1'b1, 16'hB18D);
        set_ch(2, 12, 9, 2'b10, 1'b1, 1'b0, 1'b0, 16'h0096);
        set_ch(3, 20, 6, 2'b11, 1'b0, 1'b1, 1'b1, 16'h7777);
        run_frame(); run_frame();
        @(negedge clk);
        chk(rx_word[0 +: 16] == last_rx[0], "R10 powered-down rx_word held ch0", 32'(rx_word[0 +: 16]), 32'(last_rx[0]));
        chk(rx_word[48 +: 16] == last_rx[3], "R10 powered-down rx_word held ch3", 32'(rx_word[48 +: 16]), 32'(last_rx[3]));

        // Phase 3: delay 7, rising edge, linear on both directions
        tx_tag = "R2 R3 R7 R11";
        cfg_dly = 2'd2; cfg_tx_fall = 1'b0;
        set_ch(0, 29, 29, 2'b11, 1'b0, 1'b0, 1'b0, 16'h0081);
        set_ch(1, 0, 0, 2'b10, 1'b1, 1'b0, 1'b1, 16'hE43B);
        set_ch(2, 1, 28, 2'b01, 1'b1, 1'b0, 1'b0, 16'h006A);
        set_ch(3, 2, 14, 2'b01, 1'b0, 1'b0, 1'b1, 16'h5AC7);
        run_frame(); run_frame();

        // Phase 4: reserved delay code acts as none, falling edge, unrouted channel, last slot
        tx_tag = "R2 R4 R5 R7";
        cfg_dly = 2'd3; cfg_tx_fall = 1'b1;
        set_ch(0, 3, 31, 2'b00, 1'b0, 1'b0, 1'b0, 16'h00FF);
        set_ch(1, 3, 0, 2'b01, 1'b1, 1'b0, 1'b1, 16'h2D4E);
        set_ch(2, 31, 15, 2'b11, 1'b0, 1'b0, 1'b0, 16'h00B2);
        set_ch(3, 5, 31, 2'b10, 1'b1, 1'b0, 1'b1, 16'h9C61);
        run_frame(); run_frame();

        repeat (8) @(negedge clk);
        chk(rxq.size() == 0, "R6 all expected rx words delivered", 32'(rxq.size()), 0);
        chk(txq.size() == 0, "R4 all tx bits observed", 32'(txq.size()), 0);
        done = 1;
        summary();
    end

endmodule